// File: doc/BRIEF.md
# Interrupt Moderation Counter

This block throttles a DMA interrupt before it reaches the host interrupt line. Software programs a threshold and a control word through a small register port. While the block is enabled, a counter advances on every core clock or only on cycles where an external tick strobe is high. When the count meets the threshold, a sticky status flag is raised, a one-cycle release pulse is issued, and the pending interrupt input is let through to the output. While the flag is low and the block is enabled, the interrupt is held back. When the block is disabled, the interrupt passes straight through.

Two run modes are offered. In one-shot mode the counter parks at the threshold until software clears or disables it. In continuous mode the counter reloads to zero at each threshold hit and runs again. A self-clearing clear bit in the control word zeroes both the counter and the flag. The count register can only be read.

The sequencing is a three-state machine. ST_IDLE means disabled. ST_RUN means counting toward the threshold. ST_HOLD means a one-shot period has completed.
- ST_IDLE to ST_RUN: a control write that sets the enable bit.
- Any state to ST_IDLE: a control write that clears the enable bit.
- ST_RUN to ST_HOLD: the threshold is reached in one-shot mode.
- ST_RUN to ST_RUN: the threshold is reached in continuous mode; the count reloads to zero.
- ST_HOLD to ST_RUN: a control write with the clear bit set and the enable bit set.

Top module: `irq_moderation_timer`

## Requirements
- R1: After reset, the threshold, count and control registers read 0, `release_o` is 0, and the block is disabled.
- R2: Write and read address 0 is the threshold, 1 is the count and 2 is the control word. Address 3 reads 0. Control bits are: 0 enable, 1 external tick select, 2 continuous mode, 3 clear, 4 reached flag. All other bits read 0.
- R3: When the block is enabled with bit 1 = 0, the count rises by one on each clock edge while it is below a nonzero threshold.
- R4: When bit 1 = 1, the count rises only on clock edges where `ext_tick_i` is high.
- R5: In one-shot mode (bit 2 = 0), an edge at which the count is at or above the threshold sets the flag and pulses `release_o` for one cycle. After that the count and flag stay unchanged until a clear or disable.
- R6: In continuous mode (bit 2 = 1), an edge at which the count is at or above the threshold reloads the count to 0, pulses `release_o` for one cycle and sets the flag. The flag stays set across later periods.
- R7: Writing a control word with bit 3 = 1 zeroes the count and the flag. Bit 3 always reads back as 0.
- R8: Writes to address 1 leave the count unchanged.
- R9: A threshold of 0 counts as reached at the first non-write edge after the block is enabled.
- R10: A control write with bit 0 = 0 clears the flag, stops counting and keeps the count value.
- R11: `irq_out_o` equals `irq_pend_i` while the block is disabled. While it is enabled, `irq_out_o` equals `irq_pend_i` AND (flag OR `release_o`).
- R12: The edge that takes a control write performs no count step and no threshold check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| ext_tick_i | input | 1 | External count strobe |
| irq_pend_i | input | 1 | Pending interrupt from the cause logic |
| irq_out_o | output | 1 | Gated interrupt to the host |
| release_o | output | 1 | One-cycle pulse on each threshold hit |

## Verification
The assertions assume there is at most one register write per cycle. They also assume that the tick strobe and the pending input are sampled only at the rising edge, so they may change freely between edges. The bench drives every input just after the falling edge and keeps the random threshold small. Because of that, one-shot and continuous periods both complete many times in the random run. The bench also writes random control words, including the read-only flag bit and the clear bit, and checks that they act only as R2, R7 and R10 state.

// File: rtl/itm_pkg.sv
package itm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } itm_state_e;

    localparam logic [1:0] ADDR_THR  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int BIT_EN   = 0;
    localparam int BIT_EXT  = 1;
    localparam int BIT_CONT = 2;
    localparam int BIT_CLR  = 3;
    localparam int BIT_FLAG = 4;
endpackage

// File: rtl/itm_cfg_regs.sv
module itm_cfg_regs
    import itm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              flag_i,
    output logic [CNT_W-1:0]  thr_o,
    output logic              en_o,
    output logic              ext_o,
    output logic              cont_o,
    output logic              ctrl_wr_o,
    output logic              clr_o,
    output logic              new_en_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [CNT_W-1:0] thr_q;
    logic             en_q, ext_q, cont_q;

    assign ctrl_wr_o = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign clr_o     = ctrl_wr_o && wr_data_i[BIT_CLR];
    assign new_en_o  = wr_data_i[BIT_EN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '0;
            en_q   <= 1'b0;
            ext_q  <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            if (wr_en_i && (wr_addr_i == ADDR_THR))
                thr_q <= wr_data_i[CNT_W-1:0];
            if (ctrl_wr_o) begin
                en_q   <= wr_data_i[BIT_EN];
                ext_q  <= wr_data_i[BIT_EXT];
                cont_q <= wr_data_i[BIT_CONT];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_THR:  rd_data_o = DATA_W'(thr_q);
            ADDR_CNT:  rd_data_o = DATA_W'(cnt_i);
            ADDR_CTRL: begin
                rd_data_o[BIT_EN]   = en_q;
                rd_data_o[BIT_EXT]  = ext_q;
                rd_data_o[BIT_CONT] = cont_q;
                rd_data_o[BIT_FLAG] = flag_i;
            end
            default:   rd_data_o = '0;
        endcase
    end

    assign thr_o  = thr_q;
    assign en_o   = en_q;
    assign ext_o  = ext_q;
    assign cont_o = cont_q;
endmodule

// File: rtl/itm_count_fsm.sv
module itm_count_fsm
    import itm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             ext_i,
    input  logic             cont_i,
    input  logic             ctrl_wr_i,
    input  logic             clr_i,
    input  logic             new_en_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             rel_o,
    output itm_state_e       st_o
);
    itm_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d, rel_q, rel_d;
    logic             adv, hit;

    assign adv = ext_i ? tick_i : 1'b1;
    assign hit = (thr_i == '0) || (cnt_q >= thr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            rel_q  <= rel_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        flag_d = flag_q;
        rel_d  = 1'b0;
        if (ctrl_wr_i) begin
            if (!new_en_i) begin
                st_d   = ST_IDLE;
                flag_d = 1'b0;
            end else if (clr_i || st_q == ST_IDLE) begin
                st_d = ST_RUN;
            end
            if (clr_i) begin
                cnt_d  = '0;
                flag_d = 1'b0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (hit) begin
                        flag_d = 1'b1;
                        rel_d  = 1'b1;
                        if (cont_i) cnt_d = '0;
                        else        st_d  = ST_HOLD;
                    end else if (adv) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: ;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;
    assign rel_o  = rel_q;
    assign st_o   = st_q;
endmodule

// File: rtl/irq_moderation_timer.sv
module irq_moderation_timer
    import itm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ext_tick_i,
    input  logic              irq_pend_i,
    output logic              irq_out_o,
    output logic              release_o
);
    logic [CNT_W-1:0] thr_q, cnt_q;
    logic             en_q, ext_q, cont_q, ctrl_wr, clr, new_en, flag_q;
    itm_state_e       st_q;

    itm_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .cnt_i(cnt_q), .flag_i(flag_q),
        .thr_o(thr_q), .en_o(en_q), .ext_o(ext_q), .cont_o(cont_q),
        .ctrl_wr_o(ctrl_wr), .clr_o(clr), .new_en_o(new_en),
        .rd_data_o(rd_data_o)
    );

    itm_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .thr_i(thr_q), .ext_i(ext_q), .cont_i(cont_q),
        .ctrl_wr_i(ctrl_wr), .clr_i(clr), .new_en_i(new_en),
        .tick_i(ext_tick_i),
        .cnt_o(cnt_q), .flag_o(flag_q), .rel_o(release_o), .st_o(st_q)
    );

    assign irq_out_o = irq_pend_i & (~en_q | flag_q | release_o);
endmodule

// File: rtl/itm_checker.sv
module itm_checker
    import itm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              irq_out_o,
    input logic              release_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q,
    input logic              en_q,
    input itm_state_e        st_q
);
    logic ctl_w;
    assign ctl_w = wr_en_i && (wr_addr_i == ADDR_CTRL);

    assert_release_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> flag_q);

    assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!flag_q && !release_o));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && wr_data_i[BIT_CLR]) |=> (cnt_q == '0 && !flag_q));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !ctl_w) |=> ($stable(cnt_q) && flag_q));

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctl_w) |=> $stable(cnt_q));

    assert_gate_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !flag_q) |-> !irq_out_o);
endmodule

bind irq_moderation_timer itm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .irq_out_o(irq_out_o), .release_o(release_o),
    .cnt_q(cnt_q), .flag_q(flag_q), .en_q(en_q), .st_q(st_q)
);

// File: tb/irq_moderation_timer_bench.sv
`timescale 1ns/100ps
module irq_moderation_timer_bench;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          tick = 1'b0, pend = 1'b0, irq_out, rel;

    int checks = 0, fails = 0;

    // reference state, derived from the requirements
    int  m_thr = 0, m_cnt = 0;
    bit  m_en = 0, m_ext = 0, m_cont = 0, m_flag = 0, m_hold = 0, m_rel = 0;

    always #2.5 clk = ~clk;

    irq_moderation_timer #(.DATA_W(DW), .CNT_W(CW)) u_irq_moderation_timer (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ext_tick_i(tick), .irq_pend_i(pend), .irq_out_o(irq_out),
        .release_o(rel)
    );

    function automatic int exp_ctrl();
        return (int'(m_flag) << 4) | (int'(m_cont) << 2) | (int'(m_ext) << 1) | int'(m_en);
    endfunction

    function automatic bit exp_irq(bit p);
        return p & (!m_en | m_flag | m_rel);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic sample(string tag);
        rd_addr = 2'd1; #0.3;
        chk(tag, "count", int'(rd_data), m_cnt);
        rd_addr = 2'd2; #0.3;
        chk(tag, "ctrl", int'(rd_data), exp_ctrl());
        rd_addr = 2'd0; #0.3;
        chk(tag, "thr", int'(rd_data), m_thr);
        chk(tag, "release", int'(rel), int'(m_rel));
        chk(tag, "irq_out", int'(irq_out), int'(exp_irq(pend)));
    endtask

    task automatic step(bit w, logic [1:0] a, int d, bit tk, bit pd, string tag);
        bit cw;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; tick = tk; pend = pd;
        cw = w && (a == 2'd2);
        @(posedge clk);
        m_rel = 0;
        if (cw) begin
            m_en = d[0]; m_ext = d[1]; m_cont = d[2];
            if (d[3]) begin m_cnt = 0; m_flag = 0; m_hold = 0; end
            if (!d[0]) begin m_flag = 0; m_hold = 0; end
        end else if (m_en && !m_hold) begin
            if (m_thr == 0 || m_cnt >= m_thr) begin
                m_flag = 1; m_rel = 1;
                if (m_cont) m_cnt = 0; else m_hold = 1;
            end else if (!m_ext || tk) begin
                m_cnt++;
            end
        end
        if (w && a == 2'd0) m_thr = d & ((1 << CW) - 1);
        #0.5;
        wr_en = 1'b0;
        sample(tag);
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #0.5;
        // R1 reset state
        sample("R1");
        @(negedge clk); rst_n = 1'b1;
        // R2 map
        step(1, 2'd0, 5, 0, 1, "R2");
        rd_addr = 2'd3; #0.3; chk("R2", "addr3", int'(rd_data), 0);
        // R11 pass-through while disabled
        step(0, 2'd0, 0, 0, 1, "R11");
        // R3 clock counting, R5 one-shot
        step(1, 2'd2, 32'h1, 0, 1, "R3");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R3");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R5");
        chk("R5", "flag held", int'(m_flag), 1);
        // R8 count read-only
        step(1, 2'd1, 32'h55, 0, 1, "R8");
        // R7 clear, bit3 reads 0
        step(1, 2'd2, 32'h9, 0, 1, "R7");
        // R12 ctrl write: no step
        step(0, 0, 0, 0, 0, "R12");
        step(1, 2'd2, 32'h1, 0, 0, "R12");
        // R4 ext tick
        step(1, 2'd2, 32'hB, 0, 1, "R4");
        for (int i = 0; i < 10; i++) step(0, 0, 0, (i % 3) == 0, 1, "R4");
        // R6 continuous
        step(1, 2'd0, 2, 0, 1, "R6");
        step(1, 2'd2, 32'hD, 0, 1, "R6");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, i[0], "R6");
        // R9 zero threshold
        step(1, 2'd0, 0, 0, 1, "R9");
        step(1, 2'd2, 32'h9, 0, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        chk("R9", "flag at once", int'(m_flag), 1);
        // R10 disable keeps count
        step(1, 2'd0, 6, 0, 1, "R10");
        step(1, 2'd2, 32'h9, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        step(1, 2'd2, 32'h0, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom % 6) == 0;
            logic [1:0] a = 2'($urandom % 3);
            int d = (a == 2'd0) ? int'($urandom % 9) : int'($urandom & 32'h1F);
            step(w, a, d, 1'($urandom), 1'($urandom), "R3-R6 mix");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule